// File: doc/BRIEF.md
# Two-Thread Shared Integer Multiplier

This block is one integer multiply pipeline serving two hardware threads. Each thread has a single private holding entry in front of the multiplier. The entry is loaded from that thread's own issue queue through a valid/ready handshake. An entry holds an opcode, two operands and a destination tag. In each cycle a two-way arbiter picks one occupied entry and sends it into the pipeline. Across the two threads the unit can therefore start a new multiply every cycle. Each result comes out a fixed number of cycles after launch, together with the thread number and the tag that was stored when the entry was accepted.

Each thread also has a kill input. Raising it empties that thread's waiting entry and cancels any of that thread's operations still inside the pipeline. The other thread's work is not affected.

The design is built from state machines:
- **Entry states.** Each entry has `SLOT_EMPTY` and `SLOT_HELD`. It moves *accept* from empty to held, and *launch* or *cancel* from held back to empty.
- **Arbiter states.** The arbiter has `PRIO_T0` and `PRIO_T1`. It takes *flip to T1* after granting thread 0 and *flip to T0* after granting thread 1. With only one requester it simply grants that thread.
- **Pipeline stages.** The stages move valid bits forward each cycle, clearing any that belong to a killed thread.

Top module: `mulsh_unit`

## Requirements
- R1: While `rst_n` is low and after its release, both `in_ready` bits are 1, provided the matching kill bit is low, and `res_valid` is 0.
- R2: A thread's entry accepts when `in_valid` and `in_ready` are both 1. From the next cycle its `in_ready` stays 0 until the cycle after that entry launches or is killed. `in_ready[t]` is also 0 in any cycle where `kill[t]` is 1.
- R3: A launch in cycle c gives `res_valid` = 1 in cycle c+4. An entry accepted in cycle a, with no contention, launches in cycle a+1.
- R4: When both entries are held in the same cycle, the thread that was not granted most recently wins. Thread 0 wins first after reset.
- R5: At most one entry launches per cycle. With both threads supplying work continuously, one operation launches every cycle.
- R6: Each result carries `res_tid`, where 0 means thread 0 and 1 means thread 1. It also carries the `res_tag` captured at acceptance.
- R7: `in_op` selects the result. 2'b00 gives the low 32 bits of the product. 2'b01 gives the high 32 bits of the signed product. 2'b10 gives the high 32 bits of the unsigned product. 2'b11 behaves like 2'b00.
- R8: `kill[t]` high in a cycle stops thread t's held entry from launching in that cycle. It drops the entry, so no result is ever produced for it.
- R9: `kill[t]` high in cycle k cancels every thread-t operation that would otherwise have produced a result after cycle k. Thread (1-t) results are unchanged.
- R10: Operand, opcode and tag inputs of a thread whose `in_ready` is 0 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Per-thread request valid |
| in_ready | output | 2 | Per-thread entry can accept |
| in_op | input | 2x2 | Per-thread opcode |
| in_a | input | 2x32 | Per-thread first operand |
| in_b | input | 2x32 | Per-thread second operand |
| in_tag | input | 2x5 | Per-thread destination tag |
| kill | input | 2 | Per-thread cancel |
| res_valid | output | 1 | Result valid |
| res_tid | output | 1 | Thread owning the result |
| res_tag | output | 5 | Destination tag of the result |
| res_data | output | 32 | Selected 32-bit product half |

## Verification
The first pattern is single isolated requests from each thread. These pin down the exact launch-to-result delay and the thread and tag routing. Each opcode is run on extreme operands, such as the most negative value squared and all-ones times all-ones, which separates signed from unsigned high halves.

The second pattern is simultaneous requests and continuous two-thread streaming. Here the operand inputs keep changing while entries are held. This separates true alternation and one launch per cycle from a fixed-priority or stalling arbiter, and it shows that only accepted values are used.

The third pattern is kill pulses placed on a waiting entry and in the middle of a stream. These separate dropping one thread's work from disturbing the other's.

// File: rtl/mulsh_pkg.sv
package mulsh_pkg;

    typedef enum logic [1:0] {
        OP_MUL_LO  = 2'b00,
        OP_MUL_HS  = 2'b01,
        OP_MUL_HU  = 2'b10,
        OP_MUL_RSV = 2'b11
    } mul_op_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic {
        PRIO_T0 = 1'b0,
        PRIO_T1 = 1'b1
    } prio_state_e;

endpackage

// File: rtl/mulsh_slot.sv
module mulsh_slot
    import mulsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              kill,
    input  logic              grant,
    output logic              req,
    output logic [1:0]        held_op,
    output logic [DATA_W-1:0] held_a,
    output logic [DATA_W-1:0] held_b,
    output logic [TAG_W-1:0]  held_tag
);

    slot_state_e state_q, state_d;
    logic        accept;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // Next state: accept, launch, cancel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (accept)         state_d = SLOT_HELD;
            SLOT_HELD:  if (kill || grant)  state_d = SLOT_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        req      = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: in_ready = !kill;
            SLOT_HELD:  req      = !kill;
        endcase
    end

    assign accept = in_valid && in_ready;

    // Payload captured at acceptance only
    always_ff @(posedge clk) begin
        if (accept) begin
            held_op  <= in_op;
            held_a   <= in_a;
            held_b   <= in_b;
            held_tag <= in_tag;
        end
    end

    assert_hold_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    assert_free_after_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (in_ready || kill));

endmodule

// File: rtl/mulsh_arb.sv
module mulsh_arb
    import mulsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] grant,
    output logic       gid
);

    prio_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PRIO_T0;
        else        state_q <= state_d;
    end

    // Grant: favoured thread first, otherwise whoever asks
    always_comb begin
        grant = 2'b00;
        unique case (state_q)
            PRIO_T0: begin
                if (req[0])      grant = 2'b01;
                else if (req[1]) grant = 2'b10;
            end
            PRIO_T1: begin
                if (req[1])      grant = 2'b10;
                else if (req[0]) grant = 2'b01;
            end
        endcase
    end

    assign gid = grant[1];

    // Flip to T1 after granting T0, flip to T0 after granting T1
    always_comb begin
        state_d = state_q;
        if (grant[0])      state_d = PRIO_T1;
        else if (grant[1]) state_d = PRIO_T0;
    end

    assert_alt_to_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && $past(grant) == 2'b01) |-> grant == 2'b10);

    assert_alt_to_t0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && $past(grant) == 2'b10) |-> grant == 2'b01);

    assert_single_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|req) == (|grant)));

endmodule

// File: rtl/mulsh_pipe.sv
module mulsh_pipe
    import mulsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5,
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_tid,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [1:0]        kill,
    output logic              out_valid,
    output logic              out_tid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data
);

    localparam int PW   = 2 * DATA_W;
    localparam int XW   = DATA_W + 1;
    localparam int LAST = STAGES - 1;

    logic             v_q   [STAGES];
    logic             tid_q [STAGES];
    logic [1:0]       op_q  [STAGES];
    logic [TAG_W-1:0] tag_q [STAGES];
    logic [PW-1:0]    prod_q[1:LAST];
    logic [DATA_W-1:0] a_q, b_q;

    logic                 sgn;
    logic signed [XW-1:0] ax, bx;
    logic signed [2*XW-1:0] pfull;
    logic [PW-1:0]        prod_c;

    // Stage 0: operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) v_q[0] <= 1'b0;
        else        v_q[0] <= in_valid;
    end

    always_ff @(posedge clk) begin
        tid_q[0] <= in_tid;
        op_q[0]  <= in_op;
        tag_q[0] <= in_tag;
        a_q      <= in_a;
        b_q      <= in_b;
    end

    // Sign or zero extension decided by opcode
    always_comb begin
        sgn    = (op_q[0] != OP_MUL_HU);
        ax     = signed'({sgn & a_q[DATA_W-1], a_q});
        bx     = signed'({sgn & b_q[DATA_W-1], b_q});
        pfull  = ax * bx;
        prod_c = pfull[PW-1:0];
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) v_q[s] <= 1'b0;
            else        v_q[s] <= v_q[s-1] && !kill[tid_q[s-1]];
        end
        always_ff @(posedge clk) begin
            tid_q[s] <= tid_q[s-1];
            op_q[s]  <= op_q[s-1];
            tag_q[s] <= tag_q[s-1];
        end
        if (s == 1) begin : g_mul
            always_ff @(posedge clk) prod_q[s] <= prod_c;
        end else begin : g_carry
            always_ff @(posedge clk) prod_q[s] <= prod_q[s-1];
        end
    end

    // Result half selection
    always_comb begin
        out_valid = v_q[LAST];
        out_tid   = tid_q[LAST];
        out_tag   = tag_q[LAST];
        unique case (mul_op_e'(op_q[LAST]))
            OP_MUL_HS, OP_MUL_HU: out_data = prod_q[LAST][PW-1:DATA_W];
            OP_MUL_LO, OP_MUL_RSV: out_data = prod_q[LAST][DATA_W-1:0];
        endcase
    end

    assert_kill_t0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kill[0] |=> !(out_valid && !out_tid));

    assert_kill_t1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kill[1] |=> !(out_valid && out_tid));

endmodule

// File: rtl/mulsh_unit.sv
module mulsh_unit
    import mulsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5,
    parameter int STAGES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             in_valid,
    output logic [1:0]             in_ready,
    input  logic [1:0][1:0]        in_op,
    input  logic [1:0][DATA_W-1:0] in_a,
    input  logic [1:0][DATA_W-1:0] in_b,
    input  logic [1:0][TAG_W-1:0]  in_tag,
    input  logic [1:0]             kill,
    output logic                   res_valid,
    output logic                   res_tid,
    output logic [TAG_W-1:0]       res_tag,
    output logic [DATA_W-1:0]      res_data
);

    localparam int THREADS = 2;

    logic [THREADS-1:0] req, grant;
    logic               gid;
    logic [1:0]         h_op  [THREADS];
    logic [DATA_W-1:0]  h_a   [THREADS];
    logic [DATA_W-1:0]  h_b   [THREADS];
    logic [TAG_W-1:0]   h_tag [THREADS];

    for (genvar t = 0; t < THREADS; t++) begin : g_slot
        mulsh_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[t]),
            .in_ready (in_ready[t]),
            .in_op    (in_op[t]),
            .in_a     (in_a[t]),
            .in_b     (in_b[t]),
            .in_tag   (in_tag[t]),
            .kill     (kill[t]),
            .grant    (grant[t]),
            .req      (req[t]),
            .held_op  (h_op[t]),
            .held_a   (h_a[t]),
            .held_b   (h_b[t]),
            .held_tag (h_tag[t])
        );
    end

    mulsh_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant),
        .gid   (gid)
    );

    assert_kill_blocks_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & kill) == 2'b00);

    mulsh_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W), .STAGES(STAGES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (|grant),
        .in_tid    (gid),
        .in_op     (h_op[gid]),
        .in_a      (h_a[gid]),
        .in_b      (h_b[gid]),
        .in_tag    (h_tag[gid]),
        .kill      (kill),
        .out_valid (res_valid),
        .out_tid   (res_tid),
        .out_tag   (res_tag),
        .out_data  (res_data)
    );

endmodule

// File: tb/tb_mulsh_unit.sv
`timescale 1ns/1ps
module tb_mulsh_unit;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       in_valid;
    logic [1:0]       in_ready;
    logic [1:0][1:0]  in_op;
    logic [1:0][31:0] in_a, in_b;
    logic [1:0][4:0]  in_tag;
    logic [1:0]       kill;
    logic             res_valid, res_tid;
    logic [4:0]       res_tag;
    logic [31:0]      res_data;

    always #10 clk = ~clk;

    mulsh_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_tag(in_tag), .kill(kill),
        .res_valid(res_valid), .res_tid(res_tid), .res_tag(res_tag), .res_data(res_data)
    );

    int total = 0;
    int fails = 0;
    string phase = "";

    typedef struct {
        int          due;
        bit          tid;
        logic [4:0]  tag;
        logic [31:0] data;
    } ent_t;

    ent_t q[$];
    int          cyc;
    bit          m_held [2];
    logic [1:0]  m_op   [2];
    logic [31:0] m_a    [2];
    logic [31:0] m_b    [2];
    logic [4:0]  m_tag  [2];
    int          m_prio;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d actual=%h expected=%h", req, phase, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mul(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        longint    sp;
        logic [63:0] up;
        sp = longint'($signed(a)) * longint'($signed(b));
        up = {32'd0, a} * {32'd0, b};
        case (op)
            2'b01:   return sp[63:32];
            2'b10:   return up[63:32];
            default: return sp[31:0];
        endcase
    endfunction

    // One clock of comparison and behavioural model update
    task automatic step();
        bit rdy [2];
        bit rq  [2];
        int g;
        bit ev;
        ent_t e;
        #1;
        for (int t = 0; t < 2; t++) begin
            rdy[t] = !m_held[t] && !kill[t];
            rq[t]  = m_held[t] && !kill[t];
            check("R2", {63'd0, in_ready[t]}, {63'd0, rdy[t]});
        end
        ev = 1'b0;
        foreach (q[i]) if (q[i].due == cyc) begin ev = 1'b1; e = q[i]; end
        check("R3", {63'd0, res_valid}, {63'd0, ev});
        if (ev) begin
            check("R6", {63'd0, res_tid}, {63'd0, e.tid});
            check("R6", {59'd0, res_tag}, {59'd0, e.tag});
            check("R7", {32'd0, res_data}, {32'd0, e.data});
        end
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due <= cyc) q.delete(i);
            else if (kill[q[i].tid]) q.delete(i);
        end
        g = -1;
        if (rq[0] && rq[1]) g = m_prio;
        else if (rq[0])     g = 0;
        else if (rq[1])     g = 1;
        if (g >= 0) begin
            e.due  = cyc + 4;
            e.tid  = g[0];
            e.tag  = m_tag[g];
            e.data = ref_mul(m_op[g], m_a[g], m_b[g]);
            q.push_back(e);
            m_prio = 1 - g;
        end
        for (int t = 0; t < 2; t++) begin
            if (kill[t] || (g == t)) m_held[t] = 1'b0;
            else if (rdy[t] && in_valid[t]) begin
                m_held[t] = 1'b1;
                m_op[t]   = in_op[t];
                m_a[t]    = in_a[t];
                m_b[t]    = in_b[t];
                m_tag[t]  = in_tag[t];
            end
        end
        cyc++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 2'b00;
        kill     = 2'b00;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic req1(int t, logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] tag);
        in_valid[t] = 1'b1;
        in_op[t]    = op;
        in_a[t]     = a;
        in_b[t]     = b;
        in_tag[t]   = tag;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = '0; in_op = '0; in_a = '0; in_b = '0; in_tag = '0; kill = '0;
        cyc = 0; m_prio = 0;
        for (int t = 0; t < 2; t++) begin
            m_held[t] = 1'b0; m_op[t] = '0; m_a[t] = '0; m_b[t] = '0; m_tag[t] = '0;
        end
        repeat (3) @(negedge clk);
        phase = "R1 reset";
        #1;
        check("R1", {62'd0, in_ready}, 64'd3);
        check("R1", {63'd0, res_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // Single requests, every opcode, both threads
        phase = "R3 R6 R7 single";
        req1(0, 2'b00, 32'd7, 32'hFFFF_FFFD, 5'd5); step(); idle(6);
        req1(1, 2'b01, 32'h8000_0000, 32'h8000_0000, 5'd17); step(); idle(6);
        req1(0, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd30); step(); idle(6);
        req1(1, 2'b01, 32'hFFFF_FFFF, 32'h0000_0003, 5'd2); step(); idle(6);
        req1(0, 2'b11, 32'h1234_5678, 32'h9ABC_DEF0, 5'd9); step(); idle(6);

        // Simultaneous requests alternate
        phase = "R4 alternation";
        for (int r = 0; r < 3; r++) begin
            req1(0, 2'b00, 32'd100 + r, 32'd3, 5'd1);
            req1(1, 2'b00, 32'd200 + r, 32'd5, 5'd2);
            step();
            in_valid = 2'b00;
            idle(7);
        end

        // Continuous streaming, operands changing while held
        phase = "R5 R10 stream";
        for (int i = 0; i < 80; i++) begin
            for (int t = 0; t < 2; t++)
                req1(t, 2'($urandom), $urandom, $urandom, 5'($urandom));
            step();
        end
        idle(8);

        // Kill of a waiting entry
        phase = "R8 kill waiting";
        req1(1, 2'b00, 32'd11, 32'd13, 5'd21); step();
        in_valid = 2'b00; kill = 2'b10; step();
        idle(7);
        req1(0, 2'b00, 32'd6, 32'd7, 5'd3);
        req1(1, 2'b00, 32'd8, 32'd9, 5'd4); step();
        in_valid = 2'b00; kill = 2'b10; step();
        idle(7);

        // Kill in the middle of a stream
        phase = "R9 kill in flight";
        for (int i = 0; i < 60; i++) begin
            for (int t = 0; t < 2; t++)
                req1(t, 2'($urandom), $urandom, $urandom, 5'($urandom));
            kill = (i % 9 == 4) ? 2'b01 : ((i % 13 == 7) ? 2'b10 : 2'b00);
            step();
        end
        idle(8);

        summary();
        $finish;
    end

endmodule